// File: doc/BRIEF.md
# Short-I/O Bus Slave Decoder

This block is the bus-facing front end of a four-channel, write-only output card on a 16-bit asynchronous backplane bus. It watches the address strobe, the two data strobes, the read/write line, the address modifier, the address lines, the interrupt-acknowledge line and the long-word line. All of these are first brought into the local clock domain through a two-stage synchroniser. The card claims a cycle when the address lands in a 1 KB window selected by a 6-bit strap and the address modifier is one that the privilege strap allows.

Inside the window, four 16-bit channel registers are decoded at a fixed cluster of word offsets. For a write, the block produces one-cycle byte-lane write enables for the selected channel, together with the captured data word. Every claimed cycle is acknowledged, including reads and accesses to unused offsets, so the master never times out. Reads return no meaningful data. The acknowledge output is an active-low enable that pulls the acknowledge line low.

Top module: `shortio_slave`

## Requirements
- R1: While reset is asserted, `dtack_oe_n` is 1 and `lane_we` is all zeros.
- R2: A cycle is claimed only when byte-address bits 15..10 (`addr_i[15:10]`) equal `base_sel`; a cycle outside that window is never acknowledged.
- R3: With `priv_only`=1 the only accepted modifier is 6'h2D. With `priv_only`=0 both 6'h2D and 6'h29 are accepted. Any other modifier is never acknowledged.
- R4: No cycle is acknowledged while `iack_n` is low or `lword_n` is low.
- R5: A write to byte offset 10'h088, 10'h08A, 10'h08C or 10'h08E in the window selects channel 0, 1, 2 or 3 respectively (channel = byte-address bits 2..1). `wr_data` then carries the `data_in` word of that cycle.
- R6: `lane_we` bit 2c+1 is the high-byte enable of channel c and follows `ds_n[1]` low (data lines 15..8). Bit 2c is the low-byte enable and follows `ds_n[0]` low (data lines 7..0). A word write enables both lanes; a byte write enables only its own lane.
- R7: A claimed access to any other offset in the window is acknowledged, and `lane_we` stays zero.
- R8: A claimed read (`write_n`=1) is acknowledged, and `lane_we` stays zero.
- R9: With the inputs applied before a rising edge, `dtack_oe_n` falls after the third rising edge. A write's `lane_we` pulse lasts exactly that first acknowledge cycle.
- R10: After both data strobes go high, `dtack_oe_n` returns to 1 after the third rising edge. A bus cycle gives exactly one acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel | input | 6 | Window select strap, compared with address bits 15..10 |
| priv_only | input | 1 | 1 = accept supervisory modifier only |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 2 | Data strobes: [1] high byte, [0] low byte, active low |
| write_n | input | 1 | 0 = write cycle, 1 = read cycle |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| lword_n | input | 1 | Long-word request, active low |
| am | input | 6 | Address modifier |
| addr_i | input | 15 | Byte-address bits 15..1 |
| data_in | input | 16 | Bus data lines |
| dtack_oe_n | output | 1 | Acknowledge drive enable, active low |
| lane_we | output | 8 | Byte-lane write enables, two per channel |
| wr_data | output | 16 | Data word captured for the write |

## Verification
The acknowledge and the byte-lane write pulse are meant to begin on the same clock edge. The bench therefore samples both in the single cycle where the acknowledge first appears. It expects the lane pattern computed from the strobe mask and channel offset in that cycle and zero in every other sampled cycle.

A second coincidence exercises the interaction between acknowledge release and strobe synchronisation. The strobes are released while the acknowledge is held, and the bench counts the edges until release. It then starts the next cycle at once, to confirm that exactly one acknowledge is produced per strobe pair.

// File: rtl/shortio_pkg.sv
package shortio_pkg;
  localparam int unsigned NCH      = 4;
  localparam int unsigned LANES    = 2;
  localparam int unsigned AM_W     = 6;
  localparam int unsigned WIN_W    = 6;
  localparam int unsigned OFS_W    = 10;
  localparam logic [AM_W-1:0] AM_SUPER = 6'h2D;
  localparam logic [AM_W-1:0] AM_USER  = 6'h29;
  localparam logic [OFS_W-1:0] REG_BASE = 10'h088;

  typedef enum logic {
    CYC_IDLE = 1'b0,
    CYC_ACK  = 1'b1
  } cyc_state_e;
endpackage

// File: rtl/shortio_sync.sv
module shortio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= RST_VAL;
        end else if (s == 0) begin
          stage_q[s] <= d;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/shortio_decode.sv
module shortio_decode
  import shortio_pkg::*;
#(
  parameter int unsigned CH_W = $clog2(NCH)
) (
  input  logic [WIN_W-1:0] base_sel,
  input  logic             priv_only,
  input  logic             as_n,
  input  logic [LANES-1:0] ds_n,
  input  logic             iack_n,
  input  logic             lword_n,
  input  logic [AM_W-1:0]  am,
  input  logic [15:1]      addr,
  output logic             claim,
  output logic             reg_hit,
  output logic [CH_W-1:0]  chan
);
  localparam int unsigned CLUSTER_LSB = CH_W + 1;

  logic win_hit;
  logic am_ok;
  logic strobes;

  always_comb begin
    win_hit = (addr[15:OFS_W] == base_sel);
    am_ok   = (am == AM_SUPER) || (!priv_only && (am == AM_USER));
    strobes = !as_n && (ds_n != '1);
    claim   = strobes && win_hit && am_ok && iack_n && lword_n;
    reg_hit = (addr[OFS_W-1:CLUSTER_LSB] == REG_BASE[OFS_W-1:CLUSTER_LSB]);
    chan    = addr[CH_W:1];
  end
endmodule

// File: rtl/shortio_cycle.sv
module shortio_cycle
  import shortio_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned CH_W = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 claim,
  input  logic                 reg_hit,
  input  logic [CH_W-1:0]      chan,
  input  logic                 write_n,
  input  logic [LANES-1:0]     ds_n,
  input  logic [DW-1:0]        data_in,
  output logic                 dtack_oe_n,
  output logic [NCH*LANES-1:0] lane_we,
  output logic [DW-1:0]        wr_data
);
  cyc_state_e           state_q, state_d;
  logic [NCH*LANES-1:0] we_q, we_d, lane_mask;
  logic [DW-1:0]        data_q;
  logic                 data_en;

  genvar c, l;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      for (l = 0; l < LANES; l++) begin : g_lane
        assign lane_mask[c*LANES+l] = (chan == CH_W'(c)) && !ds_n[l];
      end
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    we_d    = '0;
    data_en = 1'b0;
    unique case (state_q)
      CYC_IDLE: begin
        if (claim) begin
          state_d = CYC_ACK;
          if (!write_n && reg_hit) begin
            we_d    = lane_mask;
            data_en = 1'b1;
          end
        end
      end
      CYC_ACK: begin
        if (ds_n == '1) begin
          state_d = CYC_IDLE;
        end
      end
      default: state_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CYC_IDLE;
      we_q    <= '0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_in;
    end
  end

  assign dtack_oe_n = (state_q != CYC_ACK);
  assign lane_we    = we_q;
  assign wr_data    = data_q;
endmodule

// File: rtl/shortio_slave.sv
module shortio_slave
  import shortio_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WIN_W-1:0]     base_sel,
  input  logic                 priv_only,
  input  logic                 as_n,
  input  logic [LANES-1:0]     ds_n,
  input  logic                 write_n,
  input  logic                 iack_n,
  input  logic                 lword_n,
  input  logic [AM_W-1:0]      am,
  input  logic [15:1]          addr_i,
  input  logic [DW-1:0]        data_in,
  output logic                 dtack_oe_n,
  output logic [NCH*LANES-1:0] lane_we,
  output logic [DW-1:0]        wr_data
);
  localparam int unsigned CH_W   = $clog2(NCH);
  localparam int unsigned CTRL_W = 1 + LANES + 3;
  localparam int unsigned BUS_W  = CTRL_W + AM_W + 15;

  logic [BUS_W-1:0]   bus_raw, bus_s;
  logic               as_s, write_s, iack_s, lword_s;
  logic [LANES-1:0]   ds_s;
  logic [AM_W-1:0]    am_s;
  logic [15:1]        addr_s;
  logic               claim, reg_hit;
  logic [CH_W-1:0]    chan;

  assign bus_raw = {as_n, ds_n, write_n, iack_n, lword_n, am, addr_i};

  shortio_sync #(
    .WIDTH  (BUS_W),
    .STAGES (SYNC_DEPTH),
    .RST_VAL({{CTRL_W{1'b1}}, {(AM_W+15){1'b0}}})
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (bus_raw),
    .q    (bus_s)
  );

  assign {as_s, ds_s, write_s, iack_s, lword_s, am_s, addr_s} = bus_s;

  shortio_decode #(.CH_W(CH_W)) u_dec (
    .base_sel (base_sel),
    .priv_only(priv_only),
    .as_n     (as_s),
    .ds_n     (ds_s),
    .iack_n   (iack_s),
    .lword_n  (lword_s),
    .am       (am_s),
    .addr     (addr_s),
    .claim    (claim),
    .reg_hit  (reg_hit),
    .chan     (chan)
  );

  shortio_cycle #(.DW(DW), .CH_W(CH_W)) u_cyc (
    .clk       (clk),
    .rst_n     (rst_n),
    .claim     (claim),
    .reg_hit   (reg_hit),
    .chan      (chan),
    .write_n   (write_s),
    .ds_n      (ds_s),
    .data_in   (data_in),
    .dtack_oe_n(dtack_oe_n),
    .lane_we   (lane_we),
    .wr_data   (wr_data)
  );
endmodule

// File: rtl/shortio_slave_chk.sv
module shortio_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  base_sel,
  input logic        as_n,
  input logic [1:0]  ds_n,
  input logic        iack_n,
  input logic        lword_n,
  input logic [15:1] addr_i,
  input logic        dtack_oe_n,
  input logic [7:0]  lane_we
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (dtack_oe_n === 1'b1 && lane_we === 8'h00);
    end
  end

  a_r2_window_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_oe_n) |-> ($past(addr_i[15:10], 2) == $past(base_sel, 2)));

  a_r4_no_iack_lword: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_oe_n) |-> ($past(iack_n, 2) && $past(lword_n, 2) && !$past(as_n, 2)));

  a_r5_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|lane_we[7:6], |lane_we[5:4], |lane_we[3:2], |lane_we[1:0]}));

  a_r9_we_inside_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != 8'h00) |-> !dtack_oe_n);

  a_r9_we_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != 8'h00) |=> (lane_we == 8'h00));

  a_r10_release_after_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtack_oe_n) |-> ($past(ds_n, 2) == 2'b11));
endmodule

bind shortio_slave shortio_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .base_sel  (base_sel),
  .as_n      (as_n),
  .ds_n      (ds_n),
  .iack_n    (iack_n),
  .lword_n   (lword_n),
  .addr_i    (addr_i),
  .dtack_oe_n(dtack_oe_n),
  .lane_we   (lane_we)
);

// File: tb/sim_shortio_slave.sv
module sim_shortio_slave;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  base_sel;
  logic        priv_only;
  logic        as_n, write_n, iack_n, lword_n;
  logic [1:0]  ds_n;
  logic [5:0]  am;
  logic [15:1] addr_i;
  logic [15:0] data_in;
  logic        dtack_oe_n;
  logic [7:0]  lane_we;
  logic [15:0] wr_data;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  shortio_slave u0 (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .priv_only(priv_only),
    .as_n(as_n), .ds_n(ds_n), .write_n(write_n), .iack_n(iack_n),
    .lword_n(lword_n), .am(am), .addr_i(addr_i), .data_in(data_in),
    .dtack_oe_n(dtack_oe_n), .lane_we(lane_we), .wr_data(wr_data)
  );

  typedef struct packed {
    logic [5:0]  v_am;
    logic [15:0] v_addr;
    logic        v_wr;
    logic [1:0]  v_ds;
    logic [15:0] v_data;
    logic        v_ack;
    logic [7:0]  v_we;
  } vec_t;

  // window base 6'h05 -> byte addresses 16'h1400..16'h17FF, priv_only = 0
  localparam vec_t VECS [10] = '{
    '{6'h2D, 16'h1488, 1'b1, 2'b00, 16'hA5C3, 1'b1, 8'b0000_0011}, // R5 R6 ch0 word
    '{6'h29, 16'h148A, 1'b1, 2'b00, 16'h1234, 1'b1, 8'b0000_1100}, // R3 R5 ch1 user AM
    '{6'h2D, 16'h148C, 1'b1, 2'b10, 16'h00F0, 1'b1, 8'b0001_0000}, // R6 ch2 low byte
    '{6'h2D, 16'h148E, 1'b1, 2'b01, 16'h7E00, 1'b1, 8'b1000_0000}, // R6 ch3 high byte
    '{6'h2D, 16'h1488, 1'b0, 2'b00, 16'hFFFF, 1'b1, 8'b0000_0000}, // R8 read
    '{6'h2D, 16'h1490, 1'b1, 2'b00, 16'h5555, 1'b1, 8'b0000_0000}, // R7 past cluster
    '{6'h2D, 16'h1400, 1'b1, 2'b00, 16'h6666, 1'b1, 8'b0000_0000}, // R7 window start
    '{6'h2D, 16'h1888, 1'b1, 2'b00, 16'h7777, 1'b0, 8'b0000_0000}, // R2 wrong window
    '{6'h39, 16'h1488, 1'b1, 2'b00, 16'h8888, 1'b0, 8'b0000_0000}, // R3 foreign AM
    '{6'h2D, 16'h1788, 1'b1, 2'b00, 16'h9999, 1'b1, 8'b0000_0000}  // R7 window end
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_cycle(input vec_t v, input string req, input logic ia, input logic lw);
    int got = -1;
    logic [7:0]  we_at = '0;
    logic [15:0] wd_at = '0;
    logic [7:0]  stray = '0;
    @(negedge clk);
    am = v.v_am; addr_i = v.v_addr[15:1]; write_n = ~v.v_wr;
    data_in = v.v_data; iack_n = ia; lword_n = lw;
    as_n = 1'b0; ds_n = v.v_ds;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (!dtack_oe_n && got < 0) begin
        got = k; we_at = lane_we; wd_at = wr_data;
      end else begin
        stray |= lane_we;
      end
    end
    if (v.v_ack) begin
      check(got == 3, req, "R9 ack latency", got, 3);
      check(we_at == v.v_we, req, "lane enables", we_at, v.v_we);
      if (v.v_we != 0) check(wd_at == v.v_data, req, "R5 write data", wd_at, v.v_data);
    end else begin
      check(got < 0, req, "unexpected ack", got, -1);
    end
    check(stray == 0, req, "R9 enable outside first ack cycle", stray, 0);
    as_n = 1'b1; ds_n = 2'b11;
    if (v.v_ack) begin
      got = -1;
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk);
        if (dtack_oe_n && got < 0) got = k;
      end
      check(got == 3, req, "R10 release latency", got, 3);
    end else begin
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    int wd = 0;
    while (wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected finish", wd);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    vec_t d;
    rst_n = 1'b0; base_sel = 6'h05; priv_only = 1'b0;
    as_n = 1'b1; ds_n = 2'b11; write_n = 1'b1; iack_n = 1'b1; lword_n = 1'b1;
    am = '0; addr_i = '0; data_in = '0;
    repeat (3) @(negedge clk);
    check(dtack_oe_n == 1'b1, "R1", "reset ack", dtack_oe_n, 1);
    check(lane_we == 8'h00, "R1", "reset enables", lane_we, 0);
    // strobes active during reset must not matter
    as_n = 1'b0; ds_n = 2'b00; am = 6'h2D; addr_i = 15'h0A44;
    repeat (3) @(negedge clk);
    check(dtack_oe_n == 1'b1, "R1", "ack held in reset", dtack_oe_n, 1);
    as_n = 1'b1; ds_n = 2'b11;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    foreach (VECS[i]) run_cycle(VECS[i], "table", 1'b1, 1'b1);

    // R3: privilege strap
    priv_only = 1'b1;
    d = VECS[1]; d.v_ack = 1'b0; d.v_we = '0;
    run_cycle(d, "R3 user AM with strap", 1'b1, 1'b1);
    run_cycle(VECS[0], "R3 super AM with strap", 1'b1, 1'b1);
    priv_only = 1'b0;

    // R4: IACK and LWORD block the card
    d = VECS[0]; d.v_ack = 1'b0; d.v_we = '0;
    run_cycle(d, "R4 iack low", 1'b0, 1'b1);
    run_cycle(d, "R4 lword low", 1'b1, 1'b0);

    // R2: other strap value moves the window
    base_sel = 6'h06;
    d = VECS[0]; d.v_addr = 16'h1888;
    run_cycle(d, "R2 moved window", 1'b1, 1'b1);
    base_sel = 6'h05;

    // R10: back-to-back cycles give one ack each
    run_cycle(VECS[3], "R10 back-to-back a", 1'b1, 1'b1);
    run_cycle(VECS[2], "R10 back-to-back b", 1'b1, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule